// File: doc/BRIEF.md
# Branch History Table Predictor

This block sits beside the fetch stage and answers one question for every fetch address: where should the next fetch come from? It holds a small, fully associative table. Each entry records the full address of a branch, a two-bit direction history and the last reported target address. When the fetch address matches a valid entry and the history leans towards taken, the predicted next address is the stored target. In every other case it is the sequential address, which is the fetch address plus the instruction size.

The execute stage reports each resolved branch with its address, its real direction and its target. If the branch already has an entry, its history moves one step towards the real outcome and its target is refreshed. If it has no entry, a new one is written at a round-robin victim slot. The lookup is purely combinational. Updates land on the rising clock edge, so a lookup always sees the table as it stood before that cycle's update.

Top module: `bht_predictor`

## Requirements
- R1: After synchronous reset, every entry is invalid, so every lookup misses until a branch is reported.
- R2: On a miss, pred_hit and pred_taken are 0 and pred_next_pc equals fetch_pc + INSTR_BYTES (4 by default).
- R3: On a hit, pred_hit is 1 and pred_taken is bit 1 of the entry's history state. pred_next_pc is the stored target when pred_taken is 1, otherwise fetch_pc + INSTR_BYTES.
- R4: History encoding: 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. A reported taken outcome on an existing entry increments the state and a not-taken outcome decrements it, saturating at 11 and 00. The stored target is replaced by upd_target on every report.
- R5: From a strong state, one outcome against the prediction leaves the predicted direction unchanged. A second consecutive one reverses it.
- R6: A reported branch with no entry is allocated. Its state is 10 if upd_taken is 1, else 01, and its target is upd_target. It hits from the next cycle on.
- R7: Allocation uses a pointer that is 0 after reset and advances by one, modulo ENTRIES (8), on each allocation only. The ninth distinct branch after reset replaces the first one, and once valid an entry never becomes invalid except by reset.
- R8: No two valid entries ever hold the same branch address.
- R9: A lookup in the same cycle as an update sees the table contents from before that update.
- R10: While upd_valid is 0, the upd_* inputs change nothing in the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | ADDR_W | Address being fetched this cycle |
| pred_hit | output | 1 | Fetch address matched a valid entry |
| pred_taken | output | 1 | Predicted direction for the fetch address |
| pred_next_pc | output | ADDR_W | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is being reported |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome of the branch |
| upd_target | input | ADDR_W | Target address of the branch |

## Verification
Directed runs walk one branch through all four history states. They show saturation at both ends and show that one contrary outcome from a strong state is absorbed while a second one flips the prediction. Allocating nine distinct branches separates true round-robin replacement from schemes that reuse slot 0 or never evict. A lookup aimed at the branch being allocated in the same cycle exposes any bypass from the update path. Random traffic over a pool of twelve branch addresses, larger than the table, mixes hits, misses, evictions and idle reports, so that a model of the table catches mistakes in the counter, target refresh or pointer.

// File: rtl/bht_pkg.sv
`timescale 1ns/1ps
package bht_pkg;

  typedef enum logic [1:0] {
    HIST_SNT = 2'b00,
    HIST_WNT = 2'b01,
    HIST_WT  = 2'b10,
    HIST_ST  = 2'b11
  } hist_e;

  // Saturating step towards the observed outcome
  function automatic hist_e hist_step(input hist_e cur, input logic taken);
    hist_e nxt;
    nxt = cur;
    if (taken && cur != HIST_ST) nxt = hist_e'(cur + 2'd1);
    else if (!taken && cur != HIST_SNT) nxt = hist_e'(cur - 2'd1);
    return nxt;
  endfunction

  // First state of a freshly allocated entry: the weak state of its outcome
  function automatic hist_e hist_seed(input logic taken);
    return taken ? HIST_WT : HIST_WNT;
  endfunction

endpackage

// File: rtl/bht_match.sv
`timescale 1ns/1ps
module bht_match #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0]        valid,
  input  logic [ENTRIES*ADDR_W-1:0] tags,
  input  logic [ADDR_W-1:0]         key,
  output logic [ENTRIES-1:0]        hit_vec,
  output logic                      hit,
  output logic [IDX_W-1:0]          idx
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (tags[g*ADDR_W +: ADDR_W] == key);
  end

  assign hit = |hit_vec;

  // At most one bit is set, so OR-ing the indices encodes it
  always_comb begin
    idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) idx = idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/bht_rr_alloc.sv
`timescale 1ns/1ps
module bht_rr_alloc #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  output logic [IDX_W-1:0] victim
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (rst) victim <= '0;
    else if (advance) victim <= (victim == LAST) ? '0 : victim + 1'b1;
  end

endmodule

// File: rtl/bht_predictor.sv
`timescale 1ns/1ps
module bht_predictor
  import bht_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int ENTRIES     = 8,
  parameter int INSTR_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              pred_hit,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_next_pc,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]        valid_q;
  logic [ADDR_W-1:0]         tag_q   [ENTRIES];
  logic [ADDR_W-1:0]         tgt_q   [ENTRIES];
  hist_e                     state_q [ENTRIES];
  logic [ENTRIES*ADDR_W-1:0] tag_flat;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
    assign tag_flat[g*ADDR_W +: ADDR_W] = tag_q[g];
  end

  // Lookup port
  logic [ENTRIES-1:0] f_hit_vec;
  logic               f_hit;
  logic [IDX_W-1:0]   f_idx;

  bht_match #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) i_fetch_match (
    .valid(valid_q), .tags(tag_flat), .key(fetch_pc),
    .hit_vec(f_hit_vec), .hit(f_hit), .idx(f_idx)
  );

  // Update port
  logic [ENTRIES-1:0] u_hit_vec;
  logic               u_hit;
  logic [IDX_W-1:0]   u_idx;

  bht_match #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) i_upd_match (
    .valid(valid_q), .tags(tag_flat), .key(upd_pc),
    .hit_vec(u_hit_vec), .hit(u_hit), .idx(u_idx)
  );

  logic [IDX_W-1:0] victim;
  logic             alloc;

  assign alloc = upd_valid && !u_hit;

  bht_rr_alloc #(.ENTRIES(ENTRIES)) i_rr (
    .clk(clk), .rst(rst), .advance(alloc), .victim(victim)
  );

  logic [IDX_W-1:0] wr_idx;
  hist_e            wr_state;

  always_comb begin
    wr_idx   = u_hit ? u_idx : victim;
    wr_state = u_hit ? hist_step(state_q[u_idx], upd_taken) : hist_seed(upd_taken);
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (alloc) valid_q[wr_idx] <= 1'b1;
  end

  // Payload arrays: one write port, no reset
  always_ff @(posedge clk) begin
    if (upd_valid && !rst) begin
      tag_q[wr_idx]   <= upd_pc;
      tgt_q[wr_idx]   <= upd_target;
      state_q[wr_idx] <= wr_state;
    end
  end

  logic [ADDR_W-1:0] seq_pc;
  logic              hist_taken;
  hist_e             hit_state;

  always_comb begin
    seq_pc       = fetch_pc + ADDR_W'(INSTR_BYTES);
    hit_state    = state_q[f_idx];
    hist_taken   = f_hit && hit_state[1];
    pred_hit     = f_hit;
    pred_taken   = hist_taken;
    pred_next_pc = hist_taken ? tgt_q[f_idx] : seq_pc;
  end

endmodule

// File: rtl/bht_predictor_chk.sv
`timescale 1ns/1ps
module bht_predictor_chk #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  fetch_pc,
  input logic               pred_hit,
  input logic               pred_taken,
  input logic               upd_valid,
  input logic [ADDR_W-1:0]  upd_pc,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] f_hit_vec,
  input logic [ENTRIES-1:0] u_hit_vec
);

  // R8
  single_match_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(f_hit_vec) && $onehot0(u_hit_vec));

  // R2
  taken_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
    pred_taken |-> pred_hit);

  // R6
  reported_then_hits_chk: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> ((fetch_pc != $past(upd_pc)) || pred_hit));

  // R7
  valid_never_drops_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(valid_q) >= $past($countones(valid_q)));

endmodule

bind bht_predictor bht_predictor_chk #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) i_chk (
  .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_hit(pred_hit),
  .pred_taken(pred_taken), .upd_valid(upd_valid), .upd_pc(upd_pc),
  .valid_q(valid_q), .f_hit_vec(f_hit_vec), .u_hit_vec(u_hit_vec)
);

// File: tb/test_bht_predictor.sv
`timescale 1ns/1ps
module test_bht_predictor;

  localparam int AW = 32;
  localparam int N  = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] fetch_pc;
  logic          pred_hit, pred_taken;
  logic [AW-1:0] pred_next_pc;
  logic          upd_valid, upd_taken;
  logic [AW-1:0] upd_pc, upd_target;

  always #5 clk = ~clk;

  bht_predictor #(.ADDR_W(AW), .ENTRIES(N), .INSTR_BYTES(4)) i_bht_predictor (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_hit(pred_hit),
    .pred_taken(pred_taken), .pred_next_pc(pred_next_pc),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference table
  bit          m_valid [N];
  logic [AW-1:0] m_tag [N];
  logic [AW-1:0] m_tgt [N];
  int          m_state [N];
  int          m_ptr;

  function automatic void m_clear();
    for (int i = 0; i < N; i++) m_valid[i] = 0;
    m_ptr = 0;
  endfunction

  function automatic int m_find(input logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (m_valid[i] && m_tag[i] == a) return i;
    return -1;
  endfunction

  function automatic void m_update(input logic [AW-1:0] a, input bit t,
                                   input logic [AW-1:0] tg);
    int k;
    k = m_find(a);
    if (k >= 0) begin
      if (t && m_state[k] < 3) m_state[k]++;
      if (!t && m_state[k] > 0) m_state[k]--;
      m_tgt[k] = tg;
    end else begin
      k = m_ptr;
      m_valid[k] = 1; m_tag[k] = a; m_tgt[k] = tg;
      m_state[k] = t ? 2 : 1;
      m_ptr = (m_ptr + 1) % N;
    end
  endfunction

  task automatic check(input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; upd_valid = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    m_clear();
  endtask

  // One cycle: drive, compare lookup against model, then commit update to model
  task automatic step(input logic [AW-1:0] fpc, input bit uv,
                      input logic [AW-1:0] upc, input bit ut,
                      input logic [AW-1:0] utg, input string req);
    int k;
    bit eh, et;
    logic [AW-1:0] en;
    @(negedge clk);
    fetch_pc = fpc; upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utg;
    #1;
    k  = m_find(fpc);
    eh = (k >= 0);
    et = eh && (m_state[k] >= 2);
    en = et ? m_tgt[k] : fpc + 4;
    check(req, "hit", {31'd0, pred_hit}, {31'd0, eh});
    check(req, "taken", {31'd0, pred_taken}, {31'd0, et});
    check(req, "next", pred_next_pc, en);
    if (uv) m_update(upc, ut, utg);
  endtask

  localparam logic [AW-1:0] A = 32'h1000, TA = 32'h2000, B = 32'h1100, C = 32'h1200;

  initial begin
    rst = 1; fetch_pc = 0; upd_valid = 0; upd_pc = 0; upd_taken = 0; upd_target = 0;
    void'($urandom(32'd7));
    do_reset();

    step(A, 0, 0, 0, 0, "R1");            // empty table
    step(A, 1, A, 1, TA, "R9");           // allocate while looking up: still a miss
    step(A, 0, 0, 0, 0, "R6");            // now weak taken
    step(A, 1, A, 1, TA, "R4");           // -> strong taken
    step(A, 1, A, 0, TA, "R5");           // predicts taken, -> weak taken
    step(A, 1, A, 0, TA, "R5");           // still taken, -> weak not-taken
    step(A, 0, 0, 0, 0, "R5");            // flipped
    step(B, 1, B, 0, 32'h3000, "R2");     // miss, allocate weak NT
    step(B, 1, B, 0, 32'h3000, "R6");     // hit, not taken, -> strong NT
    step(B, 1, B, 0, 32'h3000, "R4");     // saturate low
    step(B, 1, B, 1, 32'h3000, "R4");     // still 00 -> 01
    step(B, 0, 0, 0, 0, "R4");            // not taken
    step(A, 1, A, 1, 32'h2400, "R4");     // target refresh
    step(A, 0, 0, 0, 0, "R3");            // new target
    step(C, 0, C, 1, 32'h5000, "R10");    // idle report ignored
    step(C, 0, 0, 0, 0, "R10");

    // Round-robin replacement
    do_reset();
    for (int i = 0; i < 9; i++)
      step(32'h8000 + i * 8, 1, 32'h8000 + i * 8, 1, 32'h9000 + i, "R7");
    step(32'h8000, 0, 0, 0, 0, "R7");     // evicted
    step(32'h8008, 0, 0, 0, 0, "R7");     // survives
    step(32'h8040, 0, 0, 0, 0, "R7");     // ninth lives in slot 0
    for (int i = 0; i < 4; i++)
      step(32'h8008, 1, 32'h8008, i[0], 32'h9100, "R8");

    // Random traffic over a pool bigger than the table
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] fa, ua;
      fa = 32'h4000 + ($urandom % 12) * 4;
      ua = 32'h4000 + ($urandom % 12) * 4;
      step(fa, ($urandom % 4) != 0, ua, $urandom % 2, $urandom, "R3");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule